// File: doc/BRIEF.md
# Per-Channel Packet Length Filter and Steering

This block sits in an ingress packet path. The stream carries 64 logical channels, and packets from different channels do not interleave. For every valid beat it adds up the enabled bytes. It compares the running total against a minimum and a maximum length that are set separately for each channel. It then tags each beat with a length-error flag and with a 2-bit destination code taken from that channel's configuration.

The beats leave the block one cycle after they enter, with data, byte enables, channel, start and end unchanged. Two fields are added to each beat: the destination code and the error flag. Downstream logic uses the code to choose a path:

- `00`: the aggregate high-speed egress.
- `01`: the channel's associated low-speed egress.
- `10`: capture by the host processor.
- `11`: discard.

A simple register port reads and writes the 64 configuration entries. A packet takes a snapshot of its channel's entry at start of packet, so a write made while a packet is in flight changes only the packets that start later.

Top module: `pkt_len_steer`

## Requirements
- R1: Each of the 64 entries can be written through `cfg_wr`/`cfg_addr`/`cfg_wdata`. `cfg_rdata` returns, in the same cycle, the entry selected by `cfg_addr`. Entry layout: bits [7:0] hold the minimum length (0..255 bytes), bits [21:8] hold the maximum length (0..16383 bytes), and bits [23:22] hold the destination code.
- R2: After reset, every entry reads minimum 64, maximum 1518 and destination 00, and `out_valid` is low.
- R3: The byte count of a packet is the sum of the set bits of `in_be` over its valid beats. Each valid beat appears on the outputs exactly one cycle later, with data, byte enables, channel, start and end unchanged.
- R4: If the final byte count is below the minimum, `out_len_err` is high on the end-of-packet beat.
- R5: `out_len_err` goes high on the first beat whose running count exceeds the maximum, without waiting for the end of the packet. It stays high on every later beat of that packet.
- R6: A packet whose count equals the minimum or the maximum, or lies between them, has `out_len_err` low on every beat. This includes a zero-byte packet on a channel whose minimum is 0.
- R7: Every beat of a packet carries on `out_dest` the destination code of its channel. The encoding is 00 aggregate, 01 associated port, 10 host capture, 11 discard.
- R8: A configuration write to a channel while one of its packets is in flight does not change the limits or the destination of that packet. The next packet on that channel uses the new values.
- R9: In a cycle where `in_valid` is low, `out_valid` is low one cycle later. Byte enables presented in such a cycle do not add to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_chan | input | 6 | Logical channel of the beat |
| in_be | input | 4 | Byte enables of the beat |
| in_data | input | 32 | Beat payload |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration entry index |
| cfg_wdata | input | 24 | Configuration write data |
| cfg_rdata | output | 24 | Configuration entry at `cfg_addr` |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | First beat, delayed |
| out_eop | output | 1 | Last beat, delayed |
| out_chan | output | 6 | Channel, delayed |
| out_be | output | 4 | Byte enables, delayed |
| out_data | output | 32 | Payload, delayed |
| out_dest | output | 2 | Destination code |
| out_len_err | output | 1 | Length violation flag |

## Verification
The hardest case to reach is a configuration write that lands on a channel while that channel's packet is still in flight. The write must leave the current packet's destination and limits alone and must apply to the packet that follows. The packet task therefore takes a beat index and issues the register write on that beat, alongside the stream. It then sends a second packet on the same channel. The new maximum is chosen so that the first packet would fail it and the second packet does fail it, part way through.

// File: rtl/pkt_len_steer.sv
module pkt_len_steer #(
  parameter int NUM_CH = 64,
  parameter int DATA_W = 32,
  parameter int MINL_W = 8,
  parameter int MAXL_W = 14,
  parameter int DEF_MIN = 64,
  parameter int DEF_MAX = 1518
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic                                 in_sop,
  input  logic                                 in_eop,
  input  logic [$clog2(NUM_CH)-1:0]            in_chan,
  input  logic [DATA_W/8-1:0]                  in_be,
  input  logic [DATA_W-1:0]                    in_data,
  input  logic                                 cfg_wr,
  input  logic [$clog2(NUM_CH)-1:0]            cfg_addr,
  input  logic [MINL_W+MAXL_W+1:0]             cfg_wdata,
  output logic [MINL_W+MAXL_W+1:0]             cfg_rdata,
  output logic                                 out_valid,
  output logic                                 out_sop,
  output logic                                 out_eop,
  output logic [$clog2(NUM_CH)-1:0]            out_chan,
  output logic [DATA_W/8-1:0]                  out_be,
  output logic [DATA_W-1:0]                    out_data,
  output logic [1:0]                           out_dest,
  output logic                                 out_len_err
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int CNT_W = MAXL_W + 1;
  localparam int MAX_LO = MINL_W;
  localparam int DST_LO = MINL_W + MAXL_W;

  logic [MINL_W-1:0] min_t [NUM_CH];
  logic [MAXL_W-1:0] max_t [NUM_CH];
  logic [1:0]        dst_t [NUM_CH];

  logic [MINL_W-1:0] min_q, lim_min;
  logic [MAXL_W-1:0] max_q, lim_max;
  logic [1:0]        dst_q, lim_dst;
  logic [CNT_W-1:0]  cnt_q, tot;
  logic              over_q, over, short_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        min_t[i] <= MINL_W'(DEF_MIN);
        max_t[i] <= MAXL_W'(DEF_MAX);
        dst_t[i] <= 2'b00;
      end
    end else if (cfg_wr) begin
      min_t[cfg_addr] <= cfg_wdata[MINL_W-1:0];
      max_t[cfg_addr] <= cfg_wdata[MAX_LO +: MAXL_W];
      dst_t[cfg_addr] <= cfg_wdata[DST_LO +: 2];
    end
  end

  assign cfg_rdata = {dst_t[cfg_addr], max_t[cfg_addr], min_t[cfg_addr]};

  assign lim_min = in_sop ? min_t[in_chan] : min_q;
  assign lim_max = in_sop ? max_t[in_chan] : max_q;
  assign lim_dst = in_sop ? dst_t[in_chan] : dst_q;

  assign tot       = (in_sop ? '0 : cnt_q) + CNT_W'($countones(in_be));
  assign over      = (~in_sop & over_q) | (tot > {1'b0, lim_max});
  assign short_pkt = in_eop & (tot < CNT_W'(lim_min));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
      min_q  <= '0;
      max_q  <= '0;
      dst_q  <= '0;
    end else if (in_valid) begin
      cnt_q  <= tot;
      over_q <= over;
      min_q  <= lim_min;
      max_q  <= lim_max;
      dst_q  <= lim_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_len_err <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_len_err <= in_valid & (over | short_pkt);
    end
    out_sop  <= in_sop;
    out_eop  <= in_eop;
    out_chan <= in_chan;
    out_be   <= in_be;
    out_data <= in_data;
    out_dest <= lim_dst;
  end

  logic [1:0] prev_dest;
  logic       prev_err;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_dest <= '0;
      prev_err  <= 1'b0;
    end else if (out_valid) begin
      prev_dest <= out_dest;
      prev_err  <= out_len_err;
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> out_dest == prev_dest);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop && prev_err) |-> out_len_err);
  // R1
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata)));
endmodule

// File: tb/sim_pkt_len_steer.sv
module sim_pkt_len_steer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [5:0] in_chan = 0;
  logic [3:0] in_be = 0;
  logic [31:0] in_data = 0;
  logic cfg_wr = 0;
  logic [5:0] cfg_addr = 0;
  logic [23:0] cfg_wdata = 0;
  logic [23:0] cfg_rdata;
  logic out_valid, out_sop, out_eop, out_len_err;
  logic [5:0] out_chan;
  logic [3:0] out_be;
  logic [31:0] out_data;
  logic [1:0] out_dest;

  int checks = 0, fails = 0;
  logic [23:0] mdl [64];

  always #10 clk = ~clk;

  pkt_len_steer u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ent(input int mn, input int mx, input int d);
    return {d[1:0], mx[13:0], mn[7:0]};
  endfunction

  task automatic wr(input int a, input logic [23:0] v);
    cfg_wr = 1; cfg_addr = a[5:0]; cfg_wdata = v; mdl[a] = v;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd_chk(input int a, input string req);
    cfg_addr = a[5:0];
    #1;
    chk(cfg_rdata == mdl[a], req, cfg_rdata, mdl[a]);
  endtask

  task automatic send(input int ch, input int nbeats, input logic [3:0] be_pat,
                      input logic [3:0] last_be, input bit gap, input int wr_beat,
                      input int wr_addr, input logic [23:0] wr_val, input string req);
    int mn, mx, d, tot;
    bit over, eerr, bad;
    logic [3:0] be;
    mn = mdl[ch][7:0]; mx = mdl[ch][21:8]; d = mdl[ch][23:22];
    tot = 0; over = 0; bad = 0;
    for (int b = 0; b < nbeats; b++) begin
      be = (b == nbeats - 1) ? last_be : be_pat;
      in_valid = 1; in_sop = (b == 0); in_eop = (b == nbeats - 1);
      in_chan = ch[5:0]; in_be = be; in_data = {b[15:0], 10'd0, ch[5:0]};
      if (b == wr_beat) begin
        cfg_wr = 1; cfg_addr = wr_addr[5:0]; cfg_wdata = wr_val; mdl[wr_addr] = wr_val;
      end
      tot += $countones(be);
      over |= (tot > mx);
      eerr = over | ((b == nbeats - 1) && tot < mn);
      @(negedge clk);
      cfg_wr = 0;
      if (!bad && (!out_valid || out_dest != d[1:0] || out_len_err != eerr ||
          out_chan != ch[5:0] || out_be != be || out_sop != (b == 0) ||
          out_eop != (b == nbeats - 1) || out_data != {b[15:0], 10'd0, ch[5:0]})) begin
        bad = 1;
        $display("FAIL %s beat %0d actual dest=%0d err=%0d valid=%0d expected dest=%0d err=%0d valid=1",
                 req, b, out_dest, out_len_err, out_valid, d, eerr);
      end
      if (gap) begin
        in_valid = 0; in_be = 4'hF; in_sop = 1; in_eop = 1;
        @(negedge clk);
        if (!bad && out_valid) begin
          bad = 1;
          $display("FAIL R9 idle after beat %0d actual valid=1 expected valid=0", b);
        end
      end
    end
    in_valid = 0; in_sop = 0; in_eop = 0;
    checks++;
    if (bad) fails++;
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R2 out_valid", out_valid, 0);
    rd_chk(0, "R2 entry0");
    rd_chk(63, "R2 entry63");
    chk(mdl[0] == ent(64, 1518, 0), "R2 model", mdl[0], ent(64, 1518, 0));
  endtask

  task automatic t_regs();
    wr(5, ent(10, 100, 1));
    wr(6, ent(0, 50, 2));
    wr(63, 24'hFFFFFF);
    rd_chk(5, "R1 ch5");
    rd_chk(6, "R1 ch6");
    rd_chk(63, "R1 ch63");
    rd_chk(0, "R1 ch0 untouched");
  endtask

  task automatic t_default_len();
    send(0, 16, 4'hF, 4'hF, 0, -1, 0, 0, "R6 min boundary 64");
    send(0, 16, 4'hF, 4'h7, 0, -1, 0, 0, "R4 short 63");
    send(0, 380, 4'hF, 4'h3, 0, -1, 0, 0, "R6 max boundary 1518");
    send(0, 380, 4'hF, 4'hF, 0, -1, 0, 0, "R5 over 1520");
  endtask

  task automatic t_max_early();
    send(5, 30, 4'hF, 4'hF, 0, -1, 0, 0, "R5 early max ch5");
    send(5, 25, 4'hF, 4'hF, 0, -1, 0, 0, "R6 exact max ch5");
  endtask

  task automatic t_dest();
    for (int i = 0; i < 4; i++) wr(8 + i, ent(0, 16383, i));
    for (int i = 0; i < 4; i++) send(8 + i, 3, 4'hF, 4'h1, 0, -1, 0, 0, "R7 dest code");
    send(8, 1, 4'h0, 4'h0, 0, -1, 0, 0, "R6 zero bytes min 0");
  endtask

  task automatic t_midwrite();
    wr(7, ent(10, 1000, 2));
    send(7, 10, 4'hF, 4'hF, 0, 4, 7, ent(3, 20, 3), "R8 in-flight keeps old cfg");
    send(7, 10, 4'hF, 4'hF, 0, -1, 0, 0, "R8 next packet new cfg");
  endtask

  task automatic t_be_gaps();
    wr(12, ent(20, 200, 1));
    send(12, 10, 4'b0101, 4'b0101, 1, -1, 0, 0, "R3 partial be count 20");
    send(12, 10, 4'b0101, 4'b0001, 1, -1, 0, 0, "R3 partial be count 19");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = ent(64, 1518, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_default_len();
    t_max_early();
    t_dest();
    t_midwrite();
    t_be_gaps();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule